// File: doc/BRIEF.md
# Segment Address Translator with Bounds

This block maps a logical address onto a physical address through a small table of segment descriptors. Each descriptor holds a base, a lowest permitted offset and a highest permitted offset. A request carries a segment select and a logical offset. One cycle later the response gives the physical address, which is the base plus the offset, along with a range-error flag. The flag is raised when the offset falls outside the descriptor's inclusive limits.

Software fills the descriptors through a write port. The port names a slot, a field (base, lower limit or upper limit) and a data word. Every request produces exactly one response, including requests that fail the bounds check. A failing response carries a physical address of zero, so an out-of-range access never turns into a wrapped address.

Top module: `seg_xlate_top`

## Requirements
- R1: When `req_valid` is high on a clock edge, `rsp_valid` is high on the next edge, and `rsp_valid` is low on every other cycle. No request is dropped.
- R2: For an in-range request, `rsp_paddr` equals the selected slot's base plus `req_offset`, modulo 2^ADDR_W.
- R3: `rsp_err` is 1 when `req_offset` is below the slot's lower limit (unsigned compare). An offset equal to the lower limit is in range.
- R4: `rsp_err` is 1 when `req_offset` is above the slot's upper limit (unsigned compare). An offset equal to the upper limit is in range.
- R5: When `rsp_err` is 1, `rsp_paddr` is 0.
- R6: The write port selects a field with `wr_field`: 0 writes the base, 1 writes the lower limit, 2 writes the upper limit, and 3 is ignored and changes no slot. Only the slot named by `wr_slot` changes.
- R7: A descriptor write issued in the same cycle as a lookup of that slot does not affect that lookup. The lookup uses the old contents, and the new contents apply from the next request onward.
- R8: After reset every slot has base 0, lower limit 0 and upper limit 0. An offset of 0 then translates to 0 without error, and any nonzero offset reports an error. `rsp_valid` is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_slot | input | 2 | Slot being written |
| wr_field | input | 2 | 0 base, 1 lower limit, 2 upper limit, 3 none |
| wr_data | input | 32 | Value written into the field |
| req_valid | input | 1 | Lookup request strobe |
| req_seg | input | 2 | Segment select |
| req_offset | input | 32 | Logical offset |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 32 | Physical address, 0 on error |
| rsp_err | output | 1 | Range error |

## Verification
The bench uses the default parameters: 32-bit addresses and four slots. At this width, bases near 2^32 make the addition wrap, which exercises the modulo behaviour of R2. Full-width limits let the comparisons probe the 0 and 0xFFFFFFFF extremes. With four slots the select bits decode completely, so the bench can check that a write to one slot leaves the other three unchanged.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_LOWER = 2'd1,
    FLD_UPPER = 2'd2,
    FLD_NONE  = 2'd3
  } seg_field_e;
endpackage

// File: rtl/seg_desc_bank.sv
module seg_desc_bank
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NSEG   = 4,
  localparam int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_slot,
  input  logic [1:0]        wr_field,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_slot,
  output logic [ADDR_W-1:0] rd_base,
  output logic [ADDR_W-1:0] rd_lower,
  output logic [ADDR_W-1:0] rd_upper
);
  logic [ADDR_W-1:0] base_q  [NSEG];
  logic [ADDR_W-1:0] lower_q [NSEG];
  logic [ADDR_W-1:0] upper_q [NSEG];

  for (genvar s = 0; s < NSEG; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == SEL_W'(s));
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[s]  <= '0;
        lower_q[s] <= '0;
        upper_q[s] <= '0;
      end else if (hit) begin
        unique case (seg_field_e'(wr_field))
          FLD_BASE:  base_q[s]  <= wr_data;
          FLD_LOWER: lower_q[s] <= wr_data;
          FLD_UPPER: upper_q[s] <= wr_data;
          default: ;
        endcase
      end
    end

    // R6: a write to another slot, or with the null field, leaves this slot unchanged
    p_slot_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_slot == SEL_W'(s) && wr_field != 2'd3)
      |=> ($stable(base_q[s]) && $stable(lower_q[s]) && $stable(upper_q[s])));
  end

  assign rd_base  = base_q[rd_slot];
  assign rd_lower = lower_q[rd_slot];
  assign rd_upper = upper_q[rd_slot];
endmodule

// File: rtl/seg_bound_check.sv
module seg_bound_check #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] lower,
  input  logic [ADDR_W-1:0] upper,
  output logic              below,
  output logic              above
);
  always_comb begin
    below = offset < lower;
    above = offset > upper;
  end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NSEG   = 4,
  localparam int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_slot,
  input  logic [1:0]        wr_field,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_seg,
  input  logic [ADDR_W-1:0] req_offset,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_err
);
  logic [ADDR_W-1:0] base_w, lower_w, upper_w, sum_w;
  logic below_w, above_w, err_w;

  seg_desc_bank #(.ADDR_W(ADDR_W), .NSEG(NSEG)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_field(wr_field), .wr_data(wr_data), .rd_slot(req_seg),
    .rd_base(base_w), .rd_lower(lower_w), .rd_upper(upper_w)
  );

  seg_bound_check #(.ADDR_W(ADDR_W)) u_chk (
    .offset(req_offset), .lower(lower_w), .upper(upper_w),
    .below(below_w), .above(above_w)
  );

  assign sum_w = base_w + req_offset;
  assign err_w = below_w | above_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_err   <= err_w;
        rsp_paddr <= err_w ? '0 : sum_w;
      end
    end
  end

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_err_zero_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_paddr == '0));
  p_below_flags_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && below_w) |=> rsp_err);
  p_above_flags_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && above_w) |=> rsp_err);
  p_inrange_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !below_w && !above_w) |=> (!rsp_err && rsp_paddr == $past(sum_w)));
endmodule

// File: tb/seg_xlate_top_tb.sv
module seg_xlate_top_tb;
  logic clk = 0, rst = 1;
  logic wr_en = 0; logic [1:0] wr_slot = 0, wr_field = 0; logic [31:0] wr_data = 0;
  logic req_valid = 0; logic [1:0] req_seg = 0; logic [31:0] req_offset = 0;
  logic rsp_valid, rsp_err; logic [31:0] rsp_paddr;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [31:0] pa; logic err; string tag; } exp_t;
  exp_t q[$];
  logic [31:0] mb[4], ml[4], mu[4];

  always #2 clk = ~clk;

  seg_xlate_top u_dut (.*);

  task automatic wr(input int s, input int f, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_slot = s[1:0]; wr_field = f[1:0]; wr_data = d;
    @(negedge clk); wr_en = 0;
    if (f == 0) mb[s] = d; else if (f == 1) ml[s] = d; else if (f == 2) mu[s] = d;
  endtask

  function automatic exp_t model(int s, logic [31:0] o, string tag);
    exp_t e;
    e.err = (o < ml[s]) || (o > mu[s]);
    e.pa = e.err ? 32'd0 : mb[s] + o;
    e.tag = tag;
    return e;
  endfunction

  task automatic rq(input int s, input logic [31:0] o, input string tag);
    @(negedge clk); req_valid = 1; req_seg = s[1:0]; req_offset = o;
    q.push_back(model(s, o, tag));
    @(negedge clk); req_valid = 0;
  endtask

  // monitor: sample at negedge, away from the active edge
  always @(negedge clk) if (!rst) begin
    if (rsp_valid) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        errors++; $display("FAIL R1 unexpected response paddr=%h", rsp_paddr);
      end else begin
        e = q.pop_front();
        if (rsp_paddr !== e.pa || rsp_err !== e.err) begin
          errors++;
          $display("FAIL %s got pa=%h err=%b exp pa=%h err=%b", e.tag, rsp_paddr, rsp_err, e.pa, e.err);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mb[i] = 0; ml[i] = 0; mu[i] = 0; end
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0) begin errors++; $display("FAIL R8 rsp_valid=%b exp 0", rsp_valid); end
    rst = 0;
    rq(0, 0, "R8");
    rq(2, 1, "R8");
    rq(3, 32'hFFFF_FFFF, "R8");
    wr(1, 0, 32'h1000_0000); wr(1, 1, 32'h10); wr(1, 2, 32'h100);
    rq(1, 32'h10, "R3");
    rq(1, 32'h0F, "R3");
    rq(1, 32'h100, "R4");
    rq(1, 32'h101, "R4");
    rq(1, 32'h80, "R2");
    wr(2, 0, 32'hFFFF_FFF0); wr(2, 2, 32'hFFFF_FFFF);
    rq(2, 32'h20, "R2");
    rq(2, 32'hFFFF_FFFF, "R2");
    rq(0, 32'h5, "R5");
    wr(1, 3, 32'hDEAD_BEEF);
    rq(1, 32'h80, "R6");
    rq(0, 0, "R6");
    rq(3, 0, "R6");
    // R7: write and lookup same slot, same cycle
    @(negedge clk);
    req_valid = 1; req_seg = 1; req_offset = 32'h20;
    q.push_back(model(1, 32'h20, "R7"));
    wr_en = 1; wr_slot = 1; wr_field = 0; wr_data = 32'h2000_0000;
    @(negedge clk); req_valid = 0; wr_en = 0; mb[1] = 32'h2000_0000;
    rq(1, 32'h20, "R7");
    // R1: back-to-back requests
    @(negedge clk); req_valid = 1; req_seg = 1; req_offset = 32'h30; q.push_back(model(1, 32'h30, "R1"));
    @(negedge clk); req_seg = 2; req_offset = 32'h1; q.push_back(model(2, 32'h1, "R1"));
    @(negedge clk); req_valid = 0;
    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin errors++; $display("FAIL R1 missing %0d responses exp 0", q.size()); end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog expired got hang exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule